// File: doc/BRIEF.md
# Serial Port Sample Rate Generator

This block produces the bit-rate timing for a synchronous serial port. It selects one of four source clocks. Three are external pins and one is the system clock itself. It divides the chosen source by a programmable ratio to form a bit clock. A frame counter driven by that bit clock then produces a frame-sync pulse whose period and width are set independently.

The whole block runs in one fast system clock domain. External clock and frame-sync pins are sampled through two-flop synchronizers. Their active edges become single-cycle source ticks. The bit clock is reported in two forms: a registered level, and a one-cycle enable that marks the start of each bit period. The frame-sync output is a registered level that changes only together with that enable.

In resync mode, a rising edge on the frame-sync input restarts the divider. It also arms a single frame, so frame pulses occur only after such an edge.

Top module: `srg_clkgen`

## Requirements
- R1: While `rst` is high or `en` is low, `bclk`, `bclk_rise` and `fsync` are 0 one cycle later, and all counters restart from zero once `en` returns high.
- R2: `{mode_sel, mode_ext}` selects the source: 2'b10 is the system clock (one tick per cycle), 2'b00 is `pin_ext`, 2'b01 is `pin_rx`, and 2'b11 is `pin_tx`. Activity on a pin that is not selected produces no `bclk_rise`.
- R3: For each pin source, its polarity bit (`pol_ext`, `pol_rx`, `pol_tx`) chooses the active edge: 0 means the rising edge and 1 means the falling edge. The pin is first passed through a two-flop synchronizer.
- R4: `bclk_rise` pulses for one cycle every `div_val`+1 source ticks. With `div_val`=0 it pulses on every tick, so with the system clock as source it is high every cycle.
- R5: After each `bclk_rise`, `bclk` stays high for ceil((`div_val`+1)/2) source ticks and is low for the rest of the bit period.
- R6: Outside resync mode, the r-th `bclk_rise` after enabling (counting from 1) sets `fsync` to 1 when ((r-1) mod (`per_val`+1)) <= `wid_val`, and to 0 otherwise. `fsync` only rises together with `bclk_rise`.
- R7: With `sync_en`=1 and no rising edge yet detected on `pin_fs`, `fsync` stays 0 while `bclk_rise` keeps running.
- R8: With `sync_en`=1, a rising edge on `pin_fs` restarts the divider. Using the system clock source, if `pin_fs` is raised before clock edge t0, the next `bclk_rise` is registered at edge t0+3+`div_val`, and none is registered from t0+2 until then.
- R9: In resync mode, the frame that follows an edge is a one-shot. Its k-th bit period (counting from 1) has `fsync` = 1 when k-1 <= `wid_val`, for k up to `per_val`+1. After that, `fsync` stays 0 until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator enable |
| mode_sel | input | 1 | Source select, upper bit |
| mode_ext | input | 1 | Source select, lower bit |
| pol_ext | input | 1 | Active edge of pin_ext (1 = falling) |
| pol_rx | input | 1 | Active edge of pin_rx (1 = falling) |
| pol_tx | input | 1 | Active edge of pin_tx (1 = falling) |
| sync_en | input | 1 | Resync to pin_fs rising edges |
| pin_ext | input | 1 | Dedicated external clock pin |
| pin_rx | input | 1 | Receive clock pin |
| pin_tx | input | 1 | Transmit clock pin |
| pin_fs | input | 1 | External receive frame-sync pin |
| div_val | input | DIV_W | Divider value, ratio div_val+1 |
| per_val | input | PER_W | Frame period minus one, in bit clocks |
| wid_val | input | WID_W | Frame pulse width minus one, in bit clocks |
| bclk | output | 1 | Bit clock level |
| bclk_rise | output | 1 | One-cycle enable at each bit clock start |
| fsync | output | 1 | Frame-sync level |

## Verification
A corrupted divider count first shows as a wrong spacing between two `bclk_rise` pulses, at the next wrap, within `div_val`+1 source ticks. A wrong frame position shows as a wrong `fsync` value, sampled with a `bclk_rise`, within one frame period of `per_val`+1 bit clocks. A wrong synchronizer or edge-detect state shows as a missing or extra `bclk_rise` within three cycles of a pin edge. For that reason the bench checks every pulse interval and every `fsync` value at each `bclk_rise`, rather than sampling only occasionally.

// File: rtl/srg_clkgen.sv
module srg_clkgen #(
  parameter int DIV_W = 8,
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode_sel,
  input  logic             mode_ext,
  input  logic             pol_ext,
  input  logic             pol_rx,
  input  logic             pol_tx,
  input  logic             sync_en,
  input  logic             pin_ext,
  input  logic             pin_rx,
  input  logic             pin_tx,
  input  logic             pin_fs,
  input  logic [DIV_W-1:0] div_val,
  input  logic [PER_W-1:0] per_val,
  input  logic [WID_W-1:0] wid_val,
  output logic             bclk,
  output logic             bclk_rise,
  output logic             fsync
);
  localparam int CW = (PER_W > WID_W ? PER_W : WID_W) + 1;

  logic [3:0] s1, s2, s3;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {pin_fs, pin_tx, pin_rx, pin_ext};
      s2 <= s1;
      s3 <= s2;
    end
  end

  logic [3:0] rise_v;
  logic [2:0] fall_v, pol, act;
  assign rise_v = s2 & ~s3;
  assign fall_v = ~s2[2:0] & s3[2:0];
  assign pol    = {pol_tx, pol_rx, pol_ext};
  assign act    = (rise_v[2:0] & ~pol) | (fall_v & pol);

  logic src_tick;
  always_comb begin
    case ({mode_sel, mode_ext})
      2'b00:   src_tick = act[0];
      2'b01:   src_tick = act[1];
      2'b10:   src_tick = 1'b1;
      default: src_tick = act[2];
    endcase
  end

  logic resync;
  assign resync = sync_en & rise_v[3];

  logic [DIV_W-1:0] cnt, nc;
  logic [DIV_W:0]   hi;
  logic             wrap;
  assign wrap = cnt >= div_val;
  assign nc   = wrap ? '0 : cnt + DIV_W'(1);
  assign hi   = ({1'b0, div_val} + (DIV_W+1)'(2)) >> 1;

  logic [PER_W-1:0] fpos;
  logic [CW-1:0]    npos_x, wid_x;
  logic             run, armed;
  assign npos_x = CW'(fpos) + CW'(1);
  assign wid_x  = CW'(wid_val);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0; fpos <= '0; run <= 1'b0; armed <= 1'b0;
      bclk <= 1'b0; bclk_rise <= 1'b0; fsync <= 1'b0;
    end else if (resync) begin
      cnt <= '0; run <= 1'b0; armed <= 1'b1;
      bclk <= 1'b1; bclk_rise <= 1'b0; fsync <= 1'b0;
    end else begin
      bclk_rise <= src_tick & wrap;
      if (src_tick) begin
        cnt  <= nc;
        bclk <= {1'b0, nc} < hi;
        if (wrap) begin
          if (!run) begin
            if (!sync_en || armed) begin
              fpos <= '0; run <= 1'b1; armed <= 1'b0; fsync <= 1'b1;
            end else begin
              fsync <= 1'b0;
            end
          end else if (fpos >= per_val) begin
            if (sync_en) begin
              run <= 1'b0; fsync <= 1'b0;
            end else begin
              fpos <= '0; fsync <= 1'b1;
            end
          end else begin
            fpos  <= fpos + PER_W'(1);
            fsync <= npos_x <= wid_x;
          end
        end
      end
    end
  end
endmodule

// File: rtl/srg_clkgen_chk.sv
module srg_clkgen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             mode_sel,
  input logic             mode_ext,
  input logic             sync_en,
  input logic [DIV_W-1:0] div_val,
  input logic             bclk,
  input logic             bclk_rise,
  input logic             fsync
);
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!bclk && !bclk_rise && !fsync));

  a_r4_full_rate: assert property (@(posedge clk) disable iff (rst)
    (en && !sync_en && {mode_sel, mode_ext} == 2'b10 && div_val == '0) |=> bclk_rise);

  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (bclk_rise && div_val != '0) |=> !bclk_rise);

  a_r6_fs_rises_on_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |-> bclk_rise);

  a_r5_rise_in_high: assert property (@(posedge clk) disable iff (rst)
    bclk_rise |-> bclk);
endmodule

bind srg_clkgen srg_clkgen_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .mode_sel(mode_sel), .mode_ext(mode_ext),
  .sync_en(sync_en), .div_val(div_val), .bclk(bclk), .bclk_rise(bclk_rise),
  .fsync(fsync)
);

// File: tb/srg_clkgen_tb.sv
module srg_clkgen_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1, en = 0;
  logic mode_sel = 1, mode_ext = 0, pol_ext = 0, pol_rx = 0, pol_tx = 0, sync_en = 0;
  logic pin_fs = 0;
  logic [2:0] pins = '0;
  logic [7:0] div_val = '0;
  logic [11:0] per_val = '0;
  logic [7:0] wid_val = '0;
  logic bclk, bclk_rise, fsync;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  srg_clkgen dut_i (
    .clk(clk), .rst(rst), .en(en), .mode_sel(mode_sel), .mode_ext(mode_ext),
    .pol_ext(pol_ext), .pol_rx(pol_rx), .pol_tx(pol_tx), .sync_en(sync_en),
    .pin_ext(pins[0]), .pin_rx(pins[1]), .pin_tx(pins[2]), .pin_fs(pin_fs),
    .div_val(div_val), .per_val(per_val), .wid_val(wid_val),
    .bclk(bclk), .bclk_rise(bclk_rise), .fsync(fsync)
  );

  function automatic bit exp_fs(int r, int p, int w);
    return ((r - 1) % (p + 1)) <= w;
  endfunction

  function automatic int exp_hi(int d);
    return (d + 2) / 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic restart();
    en = 0; step(); en = 1;
  endtask

  task automatic run_int(int d, int p, int w, int nr);
    int r = 0, last = 0, len = 0;
    bit cnt_on = 0;
    mode_sel = 1; mode_ext = 0; sync_en = 0;
    div_val = 8'(d); per_val = 12'(p); wid_val = 8'(w);
    restart();
    for (int c = 1; c <= nr * (d + 1) + 4; c++) begin
      step();
      if (bclk_rise) begin
        r++;
        if (r > 1) check(c - last == d + 1, "R4 interval", c - last, d + 1);
        check(fsync == exp_fs(r, p, w), "R6 fsync", fsync, exp_fs(r, p, w));
        last = c;
        if (d > 0) begin
          cnt_on = 1; len = 0;
        end
      end
      if (cnt_on) begin
        if (bclk) len++;
        else begin
          check(len == exp_hi(d), "R5 high phase", len, exp_hi(d));
          cnt_on = 0;
        end
      end
    end
    check(r >= nr, "R4 count", r, nr);
  endtask

  task automatic run_pin(bit [1:0] sel, int tog, int d, int h, int cyc, int exp_iv);
    int r = 0, last = 0;
    {mode_sel, mode_ext} = sel; sync_en = 0; div_val = 8'(d);
    per_val = 12'd3; wid_val = 8'd0; pins = '0;
    restart();
    for (int c = 1; c <= cyc; c++) begin
      if (c % h == 0) pins[tog] = ~pins[tog];
      step();
      if (bclk_rise) begin
        r++;
        if (r > 1 && exp_iv > 0) check(c - last == exp_iv, "R2/R4 pin interval", c - last, exp_iv);
        last = c;
      end
    end
    if (exp_iv == 0) check(r == 0, "R2 unselected pin ignored", r, 0);
    else check(r >= 2, "R2 selected pin counted", r, 2);
    pins = '0;
  endtask

  task automatic run_pol(bit [1:0] sel, int idx, bit pol);
    int cr = 0, cf = 0;
    {mode_sel, mode_ext} = sel; sync_en = 0; div_val = 0;
    pol_ext = pol; pol_rx = pol; pol_tx = pol; pins = '0;
    restart();
    repeat (6) step();
    pins[idx] = 1;
    repeat (6) begin step(); if (bclk_rise) cr++; end
    pins[idx] = 0;
    repeat (6) begin step(); if (bclk_rise) cf++; end
    check(cr == (pol ? 0 : 1), "R3 rising edge count", cr, pol ? 0 : 1);
    check(cf == (pol ? 1 : 0), "R3 falling edge count", cf, pol ? 1 : 0);
    pol_ext = 0; pol_rx = 0; pol_tx = 0;
  endtask

  task automatic run_sync(int d, int p, int w);
    int rises = 0, r = 0, bad = 0, first = 0, stray = 0;
    mode_sel = 1; mode_ext = 0; sync_en = 1; pin_fs = 0;
    div_val = 8'(d); per_val = 12'(p); wid_val = 8'(w);
    restart();
    repeat (60) begin step(); if (bclk_rise) rises++; if (fsync) bad++; end
    check(bad == 0, "R7 no free-running frame", bad, 0);
    check(rises > 0, "R7 bit clock runs", rises, 1);
    step(); pin_fs = 1;
    for (int i = 1; i <= d + 4; i++) begin
      step();
      if (i == 5) pin_fs = 0;
      if (i >= 3 && i <= d + 3 && bclk_rise) stray++;
      if (i == d + 4) first = bclk_rise;
    end
    check(stray == 0, "R8 no early rise", stray, 0);
    check(first == 1, "R8 restart alignment", first, 1);
    check(fsync == 1, "R9 fsync at first bit", fsync, 1);
    r = 1;
    for (int c = 0; c < (p + 4) * (d + 1) + 8; c++) begin
      step();
      if (c == 2) pin_fs = 0;
      if (bclk_rise) begin
        r++;
        if (r <= p + 1) check(fsync == ((r - 1) <= w), "R9 one-shot frame", fsync, (r - 1) <= w);
        else check(fsync == 0, "R9 stays low after frame", fsync, 0);
      end
    end
    sync_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    void'($urandom(32'h5eed));
    en = 1;
    repeat (3) step();
    check(!bclk && !bclk_rise && !fsync, "R1 reset state", {bclk, bclk_rise, fsync}, 0);
    rst = 0;
    en = 0; bad = 0;
    repeat (20) begin step(); if (bclk || bclk_rise || fsync) bad++; end
    check(bad == 0, "R1 disabled outputs low", bad, 0);

    run_int(0, 3, 1, 12);
    run_int(3, 0, 0, 6);
    run_int(2, 4, 9, 12);
    run_int(5, 6, 2, 16);
    for (int i = 0; i < 10; i++) begin
      int d = int'($urandom_range(0, 7));
      int p = int'($urandom_range(0, 12));
      int w = int'($urandom_range(0, p + 2));
      run_int(d, p, w, 3 * (p + 1) + 2);
    end

    run_pin(2'b00, 1, 1, 3, 80, 0);
    run_pin(2'b00, 0, 1, 3, 80, 12);
    run_pin(2'b01, 2, 2, 2, 80, 0);
    run_pin(2'b01, 1, 2, 2, 80, 12);
    run_pin(2'b11, 0, 0, 4, 80, 0);
    run_pin(2'b11, 2, 0, 4, 80, 8);

    run_pol(2'b00, 0, 0);
    run_pol(2'b00, 0, 1);
    run_pol(2'b01, 1, 1);
    run_pol(2'b11, 2, 0);

    run_sync(3, 5, 1);
    run_sync(0, 3, 0);

    sync_en = 0; mode_sel = 1; mode_ext = 0; div_val = 0;
    restart();
    repeat (4) step();
    en = 0; step(); step();
    check(!bclk && !bclk_rise && !fsync, "R1 disable mid-run", {bclk, bclk_rise, fsync}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule